// File: doc/BRIEF.md
# A16 Configuration Register Slave

This block is the register-side slave of a timestamp card that sits in the 16-bit short address space of a VME backplane. A four-bit base switch picks one of sixteen 4 KB windows. An access is taken only when its address modifier is one of the two short-space codes and the top address nibble equals the switch. The lower half of the window holds a small set of 16-bit configuration registers. An access to the upper half produces only a select strobe for the shared event memory, which lies outside this block.

The registers are an identity word, a model code, an interrupt vector and a control/status word. The identity word and the vector share one offset: a read returns the identity and a write stores the vector. A second offset reads the vector back. The control/status word supports a booking scheme: after reset the first reader sees the card as free and every later reader sees it as taken, and software can release it by writing a reset bit. The same word holds an event-complete flag that is cleared by writing a one, an enable that lets the flag raise an interrupt request, a spare bit, and the two level-select jumpers. The request goes out on the line that the jumpers select. An acknowledge cycle at that level receives the stored vector.

The bus handshake is a single-cycle strobe sampled on the clock. Read data and the acknowledge come one cycle later.

Top module: `a16_cfg_slave`

## Requirements
- R1: An access is taken only when `bus_cyc` is 1, `bus_am` is 0x29 or 0x2D, and `bus_addr[15:12]` equals `base_sw`. Any other access produces no `rd_ack`, no `ram_sel` and no change of register state.
- R2: A taken access with `bus_addr[11]`=1 drives `ram_sel` high in the same cycle. It produces no `rd_ack` and changes no register.
- R3: A read at register offset 0x000 (`bus_addr[10:0]`) returns 0xFF7F. A write there stores `bus_wdata[7:0]` as the interrupt vector, and bits 15..8 of that write are ignored.
- R4: Offset 0x00C reads the vector zero-extended to 16 bits. Offset 0x002 reads 0x082C (2092). Every other register offset reads 0x0000.
- R5: The control word at offset 0x004 always reads bit14=1, bits3..2=1, and bit15, bits13..10 and bit1 as 0. Writes to these bits have no effect.
- R6: The first control-word read after reset returns bit0=0. Every later read returns bit0=1. Bit4 always reads as the inverse of bit0.
- R7: Writing the control word with bit0=1 returns the booking state to its after-reset value. It also clears the vector, bit7, bit8 and bit9, and the other bits of that write are ignored.
- R8: An `evt_done` pulse sets bit9. Writing the control word with bit9=1 clears it, and writing bit9=0 leaves it unchanged. If an event and a clearing write (or a reset write) fall in the same cycle, bit9 ends at 1.
- R9: Bit7 (interrupt enable) and bit8 (spare) are read/write.
- R10: Bit6 reads `jmp_a_out` and bit5 reads `jmp_b_out` (1 = jumper out). The selected level is 4 + 2·`jmp_a_out` + `jmp_b_out`. `irq_req[level-4]` is high, and no other request bit is high, exactly while bit9 and bit7 are both 1.
- R11: An `iack_cyc` strobe with `iack_level` equal to the selected level, while the request is active, gives `iack_ack`=1 one cycle later with the vector on `iack_vec`. Any other acknowledge strobe gives no `iack_ack`.
- R12: `rd_ack` pulses for one cycle, one cycle after each taken register-half access. For a read, `rd_data` is valid in that cycle. Synchronous `rst` clears all state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cyc | input | 1 | One-cycle access strobe |
| bus_am | input | 6 | Address modifier |
| bus_addr | input | 16 | Byte address |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 16 | Write data |
| base_sw | input | 4 | Base address switch |
| jmp_a_out | input | 1 | Upper level-select jumper, 1 = out |
| jmp_b_out | input | 1 | Lower level-select jumper, 1 = out |
| evt_done | input | 1 | Event processing complete pulse |
| iack_cyc | input | 1 | Interrupt acknowledge strobe |
| iack_level | input | 3 | Level being acknowledged |
| rd_ack | output | 1 | Register access acknowledge |
| rd_data | output | 16 | Register read data |
| ram_sel | output | 1 | Shared-memory half select |
| irq_req | output | 4 | Request per level, bit0 = level 4 |
| iack_ack | output | 1 | Acknowledge accepted |
| iack_vec | output | 8 | Vector returned on acknowledge |

## Verification
Two things can fall in the same cycle: the event-complete pulse that sets the flag, and a bus write that clears the flag or resets the register logic. The bench drives `evt_done` high in exactly the cycle that carries the write strobe. It then reads the control word back and expects the flag to be set. A lost event would show up as bit9=0 and a missing request on the selected `irq_req` line.

// File: rtl/a16cfg_pkg.sv
package a16cfg_pkg;

    localparam logic [5:0] AM_SHORT_USR = 6'h29;
    localparam logic [5:0] AM_SHORT_SUP = 6'h2D;

    localparam logic [15:0] ID_WORD    = 16'hFF7F;
    localparam logic [15:0] MODEL_WORD = 16'd2092;
    localparam logic [15:0] CSR_FIXED  = 16'h400C;

    localparam int OFS_ID    = 'h000;
    localparam int OFS_MODEL = 'h002;
    localparam int OFS_CSR   = 'h004;
    localparam int OFS_VEC   = 'h00C;

    localparam int BIT_CLAIM = 0;
    localparam int BIT_READY = 4;
    localparam int BIT_JB    = 5;
    localparam int BIT_JA    = 6;
    localparam int BIT_EN    = 7;
    localparam int BIT_SP    = 8;
    localparam int BIT_FLAG  = 9;

    localparam int JMP_N    = 2;
    localparam int IRQ_N    = 1 << JMP_N;
    localparam int LVL_W    = 3;
    localparam int LVL_BASE = 4;

    typedef enum logic [2:0] {
        ACC_OTHER,
        ACC_ID,
        ACC_MODEL,
        ACC_CSR,
        ACC_VEC
    } acc_e;

    typedef struct packed {
        logic flag;
        logic spare;
        logic irq_en;
        logic jmp_a;
        logic jmp_b;
        logic claimed;
    } ctl_t;

    function automatic logic am_ok(input logic [5:0] am);
        return (am == AM_SHORT_USR) || (am == AM_SHORT_SUP);
    endfunction

    function automatic logic [15:0] pack_csr(input ctl_t c);
        logic [15:0] v;
        v             = CSR_FIXED;
        v[BIT_FLAG]   = c.flag;
        v[BIT_SP]     = c.spare;
        v[BIT_EN]     = c.irq_en;
        v[BIT_JA]     = c.jmp_a;
        v[BIT_JB]     = c.jmp_b;
        v[BIT_READY]  = ~c.claimed;
        v[BIT_CLAIM]  = c.claimed;
        return v;
    endfunction

    function automatic logic [LVL_W-1:0] irq_level(input logic a, input logic b);
        return LVL_W'(LVL_BASE) + {1'b0, a, b};
    endfunction

endpackage

// File: rtl/a16cfg_decode.sv
module a16cfg_decode
    import a16cfg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SW_W   = 4
) (
    input  logic              bus_cyc,
    input  logic [5:0]        bus_am,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SW_W-1:0]   base_sw,
    output logic              reg_hit,
    output logic              ram_hit,
    output acc_e              kind
);
    localparam int HALF_BIT = ADDR_W - SW_W - 1;

    logic                window_hit;
    logic [HALF_BIT-1:0] ofs;

    always_comb begin
        window_hit = bus_cyc && am_ok(bus_am) &&
                     (bus_addr[ADDR_W-1 -: SW_W] == base_sw);
        reg_hit    = window_hit && !bus_addr[HALF_BIT];
        ram_hit    = window_hit &&  bus_addr[HALF_BIT];
        ofs        = bus_addr[HALF_BIT-1:0];
        if (ofs == HALF_BIT'(OFS_ID))         kind = ACC_ID;
        else if (ofs == HALF_BIT'(OFS_MODEL)) kind = ACC_MODEL;
        else if (ofs == HALF_BIT'(OFS_CSR))   kind = ACC_CSR;
        else if (ofs == HALF_BIT'(OFS_VEC))   kind = ACC_VEC;
        else                                  kind = ACC_OTHER;
    end
endmodule

// File: rtl/a16cfg_regs.sv
module a16cfg_regs
    import a16cfg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_hit,
    input  logic              bus_we,
    input  acc_e              kind,
    input  logic [DATA_W-1:0] wdata,
    input  logic              evt_done,
    input  logic              jmp_a,
    input  logic              jmp_b,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ack,
    output logic              flag_q,
    output logic              en_q,
    output logic [VEC_W-1:0]  vec_q
);
    logic  spare_q;
    logic  claimed_q;
    ctl_t  cur;
    logic  wr_csr;
    logic  wr_rst;
    logic  rd_go;

    always_comb begin
        cur.flag    = flag_q;
        cur.spare   = spare_q;
        cur.irq_en  = en_q;
        cur.jmp_a   = jmp_a;
        cur.jmp_b   = jmp_b;
        cur.claimed = claimed_q;
        wr_csr      = reg_hit && bus_we && (kind == ACC_CSR);
        wr_rst      = wr_csr && wdata[BIT_CLAIM];
        rd_go       = reg_hit && !bus_we;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ack    <= 1'b0;
            rd_data   <= '0;
            flag_q    <= 1'b0;
            en_q      <= 1'b0;
            spare_q   <= 1'b0;
            claimed_q <= 1'b0;
            vec_q     <= '0;
        end else begin
            rd_ack  <= reg_hit;
            rd_data <= '0;
            if (rd_go) begin
                unique case (kind)
                    ACC_ID:    rd_data <= ID_WORD;
                    ACC_MODEL: rd_data <= MODEL_WORD;
                    ACC_VEC:   rd_data <= DATA_W'(vec_q);
                    ACC_CSR: begin
                        rd_data   <= pack_csr(cur);
                        claimed_q <= 1'b1;
                    end
                    default:   rd_data <= '0;
                endcase
            end
            if (wr_rst) begin
                claimed_q <= 1'b0;
                vec_q     <= '0;
                en_q      <= 1'b0;
                spare_q   <= 1'b0;
                flag_q    <= 1'b0;
            end else if (wr_csr) begin
                en_q    <= wdata[BIT_EN];
                spare_q <= wdata[BIT_SP];
                if (wdata[BIT_FLAG]) flag_q <= 1'b0;
            end else if (reg_hit && bus_we && kind == ACC_ID) begin
                vec_q <= wdata[VEC_W-1:0];
            end
            if (evt_done) flag_q <= 1'b1;
        end
    end
endmodule

// File: rtl/a16cfg_irq.sv
module a16cfg_irq
    import a16cfg_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flag,
    input  logic             en,
    input  logic             jmp_a,
    input  logic             jmp_b,
    input  logic [VEC_W-1:0] vec,
    input  logic             iack_cyc,
    input  logic [LVL_W-1:0] iack_level,
    output logic [IRQ_N-1:0] irq_req,
    output logic             iack_ack,
    output logic [VEC_W-1:0] iack_vec
);
    logic [LVL_W-1:0] level;
    logic             active;

    assign level  = irq_level(jmp_a, jmp_b);
    assign active = flag && en;

    for (genvar i = 0; i < IRQ_N; i++) begin : g_line
        assign irq_req[i] = active && (level == LVL_W'(LVL_BASE + i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            iack_ack <= 1'b0;
            iack_vec <= '0;
        end else begin
            iack_ack <= 1'b0;
            iack_vec <= '0;
            if (iack_cyc && active && iack_level == level) begin
                iack_ack <= 1'b1;
                iack_vec <= vec;
            end
        end
    end
endmodule

// File: rtl/a16_cfg_slave.sv
module a16_cfg_slave
    import a16cfg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int SW_W   = 4,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cyc,
    input  logic [5:0]        bus_am,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [SW_W-1:0]   base_sw,
    input  logic              jmp_a_out,
    input  logic              jmp_b_out,
    input  logic              evt_done,
    input  logic              iack_cyc,
    input  logic [2:0]        iack_level,
    output logic              rd_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              ram_sel,
    output logic [3:0]        irq_req,
    output logic              iack_ack,
    output logic [VEC_W-1:0]  iack_vec
);
    logic             reg_hit;
    acc_e             kind;
    logic             evt_flag;
    logic             irq_en;
    logic [VEC_W-1:0] vec;

    a16cfg_decode #(.ADDR_W(ADDR_W), .SW_W(SW_W)) u_dec (
        .bus_cyc (bus_cyc),
        .bus_am  (bus_am),
        .bus_addr(bus_addr),
        .base_sw (base_sw),
        .reg_hit (reg_hit),
        .ram_hit (ram_sel),
        .kind    (kind)
    );

    a16cfg_regs #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .reg_hit (reg_hit),
        .bus_we  (bus_we),
        .kind    (kind),
        .wdata   (bus_wdata),
        .evt_done(evt_done),
        .jmp_a   (jmp_a_out),
        .jmp_b   (jmp_b_out),
        .rd_data (rd_data),
        .rd_ack  (rd_ack),
        .flag_q  (evt_flag),
        .en_q    (irq_en),
        .vec_q   (vec)
    );

    a16cfg_irq #(.VEC_W(VEC_W)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .flag      (evt_flag),
        .en        (irq_en),
        .jmp_a     (jmp_a_out),
        .jmp_b     (jmp_b_out),
        .vec       (vec),
        .iack_cyc  (iack_cyc),
        .iack_level(iack_level),
        .irq_req   (irq_req),
        .iack_ack  (iack_ack),
        .iack_vec  (iack_vec)
    );
endmodule

// File: rtl/a16cfg_checker.sv
module a16cfg_checker (
    input logic        clk,
    input logic        rst,
    input logic        bus_cyc,
    input logic        bus_we,
    input logic [15:0] bus_addr,
    input logic        ram_sel,
    input logic        rd_ack,
    input logic [15:0] rd_data,
    input logic [3:0]  irq_req,
    input logic        iack_cyc,
    input logic        iack_ack,
    input logic        evt_done,
    input logic        flag
);
    logic prev_csr_rd;

    always_ff @(posedge clk) begin
        if (rst) prev_csr_rd <= 1'b0;
        else     prev_csr_rd <= bus_cyc && !bus_we && !ram_sel &&
                                (bus_addr[10:0] == 11'h004);
    end

    // R2: a memory-half access is never acknowledged as a register access
    assert_ram_no_ack_R2: assert property (@(posedge clk) disable iff (rst)
        ram_sel |=> !rd_ack);

    // R12: an acknowledge always follows a strobe
    assert_ack_after_strobe_R12: assert property (@(posedge clk) disable iff (rst)
        rd_ack |-> $past(bus_cyc));

    // R5: fixed bits of a control-word read
    assert_csr_fixed_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && prev_csr_rd) |-> ((rd_data & 16'hFC0E) == 16'h400C));

    // R6: ready is the inverse of the booking bit
    assert_ready_inverse_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && prev_csr_rd) |-> (rd_data[4] != rd_data[0]));

    // R8: the flag only rises after an event pulse
    assert_flag_source_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(evt_done));

    // R10: at most one request line
    assert_irq_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_req));

    // R10: no request without the flag
    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_req != 4'd0) |-> flag);

    // R11: acknowledge only follows an acknowledge strobe
    assert_iack_after_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        iack_ack |-> $past(iack_cyc));
endmodule

bind a16_cfg_slave a16cfg_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .bus_cyc (bus_cyc),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .ram_sel (ram_sel),
    .rd_ack  (rd_ack),
    .rd_data (rd_data),
    .irq_req (irq_req),
    .iack_cyc(iack_cyc),
    .iack_ack(iack_ack),
    .evt_done(evt_done),
    .flag    (evt_flag)
);

// File: tb/sim_a16_cfg_slave.sv
`timescale 1ns/1ps
module sim_a16_cfg_slave;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_cyc = 1'b0;
    logic [5:0]  bus_am = 6'h29;
    logic [15:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [3:0]  base_sw = 4'h7;
    logic        jmp_a_out = 1'b0;
    logic        jmp_b_out = 1'b0;
    logic        evt_done = 1'b0;
    logic        iack_cyc = 1'b0;
    logic [2:0]  iack_level = '0;
    logic        rd_ack;
    logic [15:0] rd_data;
    logic        ram_sel;
    logic [3:0]  irq_req;
    logic        iack_ack;
    logic [7:0]  iack_vec;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;
    bit  m_busy = 0;   // bench model of the booking bit
    logic [5:0] am_list [4] = '{6'h29, 6'h2D, 6'h39, 6'h09};

    always #4 clk = ~clk;

    a16_cfg_slave u0 (
        .clk(clk), .rst(rst), .bus_cyc(bus_cyc), .bus_am(bus_am),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .base_sw(base_sw), .jmp_a_out(jmp_a_out), .jmp_b_out(jmp_b_out),
        .evt_done(evt_done), .iack_cyc(iack_cyc), .iack_level(iack_level),
        .rd_ack(rd_ack), .rd_data(rd_data), .ram_sel(ram_sel),
        .irq_req(irq_req), .iack_ack(iack_ack), .iack_vec(iack_vec)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic bus(input logic [5:0] am, input logic [15:0] addr, input logic we,
                       input logic [15:0] wd, input logic ev,
                       output logic ack, output logic [15:0] rd, output logic rs);
        @(negedge clk);
        bus_cyc = 1'b1; bus_am = am; bus_addr = addr; bus_we = we;
        bus_wdata = wd; evt_done = ev;
        #1 rs = ram_sel;
        @(negedge clk);
        bus_cyc = 1'b0; bus_we = 1'b0; evt_done = 1'b0;
        ack = rd_ack; rd = rd_data;
    endtask

    function automatic logic [15:0] reg_addr(input logic [10:0] ofs);
        return {base_sw, 1'b0, ofs};
    endfunction

    function automatic logic [15:0] exp_csr(input bit fl, input bit sp, input bit en, input bit busy);
        logic [15:0] v;
        v = 16'h400C | (16'(fl) << 9) | (16'(sp) << 8) | (16'(en) << 7) |
            (16'(jmp_a_out) << 6) | (16'(jmp_b_out) << 5);
        v = v | (busy ? 16'h0001 : 16'h0010);
        return v;
    endfunction

    task automatic csr_read(input string req, input bit fl, input bit sp, input bit en);
        logic a; logic [15:0] d; logic s;
        bus(6'h2D, reg_addr(11'h004), 1'b0, 16'h0, 1'b0, a, d, s);
        check(req, d, exp_csr(fl, sp, en, m_busy));
        m_busy = 1;
    endtask

    task automatic wr(input logic [10:0] ofs, input logic [15:0] wd, input logic ev);
        logic a; logic [15:0] d; logic s;
        bus(6'h29, reg_addr(ofs), 1'b1, wd, ev, a, d, s);
    endtask

    task automatic rd(input logic [10:0] ofs, output logic [15:0] d);
        logic a; logic s;
        bus(6'h29, reg_addr(ofs), 1'b0, 16'h0, 1'b0, a, d, s);
    endtask

    task automatic pulse_evt();
        @(negedge clk); evt_done = 1'b1;
        @(negedge clk); evt_done = 1'b0;
    endtask

    task automatic iack(input logic [2:0] lvl, output logic ack, output logic [7:0] v);
        @(negedge clk); iack_cyc = 1'b1; iack_level = lvl;
        @(negedge clk); iack_cyc = 1'b0;
        ack = iack_ack; v = iack_vec;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic a; logic s; logic [15:0] d; logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        check("R12 reset ack", 16'(rd_ack), 16'h0);
        check("R10 reset irq", 16'(irq_req), 16'h0);

        // R6: booking semantic
        csr_read("R6 first read", 0, 0, 0);
        csr_read("R6 second read", 0, 0, 0);
        csr_read("R6 third read", 0, 0, 0);

        // R3 / R4 fixed words
        rd(11'h000, d); check("R3 id", d, 16'hFF7F);
        rd(11'h002, d); check("R4 model", d, 16'h082C);
        rd(11'h008, d); check("R4 unmapped", d, 16'h0000);
        rd(11'h006, d); check("R4 unmapped 6", d, 16'h0000);

        // R1: decode sweep over switch, top nibble and modifier
        for (int sw = 0; sw < 16; sw++) begin
            base_sw = 4'(sw);
            for (int hi = 0; hi < 16; hi++) begin
                for (int k = 0; k < 4; k++) begin
                    bit take;
                    take = (hi == sw) && (k < 2);
                    bus(am_list[k], {4'(hi), 12'h000}, 1'b0, 16'h0, 1'b0, a, d, s);
                    check("R1 decode ack", 16'(a), 16'(take));
                    check("R1 decode ram_sel", 16'(s), 16'h0);
                    if (take) check("R1 decode data", d, 16'hFF7F);
                end
            end
        end
        base_sw = 4'h7;

        // R1: foreign writes leave the vector alone
        wr(11'h000, 16'h0033, 1'b0);
        bus(6'h39, 16'h7000, 1'b1, 16'h00AA, 1'b0, a, d, s);
        check("R1 bad am ack", 16'(a), 16'h0);
        bus(6'h29, 16'h3000, 1'b1, 16'h00AA, 1'b0, a, d, s);
        check("R1 bad base ack", 16'(a), 16'h0);
        rd(11'h00C, d); check("R1 vector untouched", d, 16'h0033);

        // R2: memory half
        for (int sw = 0; sw < 16; sw += 5) begin
            base_sw = 4'(sw);
            bus(6'h2D, {4'(sw), 1'b1, 11'h000}, 1'b1, 16'h00CC, 1'b0, a, d, s);
            check("R2 ram_sel", 16'(s), 16'h1);
            check("R2 no ack", 16'(a), 16'h0);
            bus(6'h29, {4'(sw), 1'b1, 11'h00C}, 1'b0, 16'h0, 1'b0, a, d, s);
            check("R2 ram_sel read", 16'(s), 16'h1);
            rd(11'h00C, d); check("R2 vector untouched", d, 16'h0033);
        end
        base_sw = 4'h7;

        // R3 / R4: vector sweep with junk in the upper byte
        for (int i = 0; i < 256; i++) begin
            wr(11'h000, {8'(~i), 8'(i)}, 1'b0);
            rd(11'h00C, d); check("R4 vector readback", d, 16'(i));
            rd(11'h000, d); check("R3 id after write", d, 16'hFF7F);
        end

        // R9 / R5: read/write bits and fixed bits
        wr(11'h004, 16'h0180, 1'b0); csr_read("R9 en+spare set", 0, 1, 1);
        wr(11'h004, 16'h0080, 1'b0); csr_read("R9 spare clear", 0, 0, 1);
        wr(11'h004, 16'h0000, 1'b0); csr_read("R9 both clear", 0, 0, 0);
        wr(11'h004, 16'hFFFE, 1'b0); csr_read("R5 fixed ignore writes", 0, 1, 1);
        wr(11'h004, 16'h0000, 1'b0); csr_read("R5 fixed after zero", 0, 0, 0);

        // R8: flag set and clear
        pulse_evt();
        csr_read("R8 event sets", 1, 0, 0);
        wr(11'h004, 16'h0000, 1'b0); csr_read("R8 zero keeps", 1, 0, 0);
        wr(11'h004, 16'h0200, 1'b0); csr_read("R8 one clears", 0, 0, 0);
        wr(11'h004, 16'h0200, 1'b1); csr_read("R8 event beats clear", 1, 0, 0);
        wr(11'h004, 16'h0200, 1'b0); csr_read("R8 clear again", 0, 0, 0);

        // R10 / R11: every jumper setting, every acknowledge level
        wr(11'h000, 16'h005A, 1'b0);
        for (int j = 0; j < 4; j++) begin
            jmp_a_out = j[1]; jmp_b_out = j[0];
            wr(11'h004, 16'h0080, 1'b0);
            @(negedge clk);
            check("R10 no flag no irq", 16'(irq_req), 16'h0);
            iack(3'(4 + j), a, v);
            check("R11 idle no ack", 16'(a), 16'h0);
            pulse_evt();
            check("R10 irq line", 16'(irq_req), 16'(4'(1) << j));
            csr_read("R10 jumper bits", 1, 0, 1);
            for (int l = 0; l < 8; l++) begin
                iack(3'(l), a, v);
                check("R11 ack", 16'(a), 16'(l == 4 + j));
                check("R11 vec", 16'(v), (l == 4 + j) ? 16'h005A : 16'h0000);
            end
            wr(11'h004, 16'h0000, 1'b0);
            @(negedge clk);
            check("R10 disabled irq", 16'(irq_req), 16'h0);
            wr(11'h004, 16'h0280, 1'b0);
            @(negedge clk);
            check("R10 cleared irq", 16'(irq_req), 16'h0);
            wr(11'h004, 16'h0000, 1'b0);
        end

        // R7: reset write
        jmp_a_out = 1'b1; jmp_b_out = 1'b0;
        wr(11'h000, 16'h0099, 1'b0);
        wr(11'h004, 16'h0180, 1'b0);
        pulse_evt();
        csr_read("R7 before reset", 1, 1, 1);
        wr(11'h004, 16'h0181, 1'b0);
        rd(11'h00C, d); check("R7 vector cleared", d, 16'h0000);
        check("R7 irq cleared", 16'(irq_req), 16'h0);
        m_busy = 0;
        csr_read("R7 first read after reset write", 0, 0, 0);
        csr_read("R7 second read", 0, 0, 0);
        wr(11'h004, 16'h0001, 1'b1);
        m_busy = 0;
        csr_read("R8 event beats reset write", 1, 0, 0);

        // R12: acknowledge timing of a write
        bus(6'h29, reg_addr(11'h002), 1'b1, 16'h1234, 1'b0, a, d, s);
        check("R12 write ack", 16'(a), 16'h1);
        @(negedge clk);
        check("R12 ack one cycle", 16'(rd_ack), 16'h0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule